// File: doc/BRIEF.md
# Bridge Port Command Register with Interrupt and Error Gating

This block holds the 16-bit command register of a virtual bridge port in configuration space. Three of its bits can be written. The other bits always read as zero. A configuration agent reaches the register with byte-enabled 16-bit accesses at a programmable byte offset (04h by default). Reads are combinational.

The writable bits control three local functions:
- **Bit 10 (INTA disable)** masks the port's own legacy interrupt. That interrupt is requested by power-management or hot-plug events. The block turns changes of the masked interrupt level into one-cycle assert and deassert message pulses. Setting the disable bit while the interrupt is asserted sends a deassert message. Clearing it while a request is still pending sends a new assert message.
- **Bit 8 (error-message enable)** allows primary-side non-fatal and fatal errors to raise an error message. The matching device-control enable inputs can also allow this. Errors received on the secondary side are reported only through the device-control enables. Each qualified error condition produces exactly one message pulse, on its rising edge.
- **Bit 6 (parity response)** gates the set strobe of the master data parity error status bit.

Top module: `bridge_cmd_reg`

## Requirements
- R1: After reset the register reads 0000h. A read whose address matches the command offset (address bit 0 ignored) returns the register on `cfg_rdata`. Any other address reads 0000h, and writes to other addresses change nothing.
- R2: Only bits 10, 8 and 6 can be written. `cfg_be[1]` gates bits 10 and 8, and `cfg_be[0]` gates bit 6. All other bits read 0 whatever is written, so writing FFFFh with both enables set reads back 0540h.
- R3: `inta_level` follows (`pme_req` OR `hp_req`) AND NOT bit 10, one cycle late. `inta_asrt_msg` pulses for one cycle in the cycle where `inta_level` rises. While bit 10 is 1, no assert message is sent.
- R4: `inta_dsrt_msg` pulses for one cycle when the masked level falls. This happens when the last request drops, or when bit 10 is set while the interrupt is asserted. The pulse appears the cycle after the write.
- R5: Clearing bit 10 while a request is pending sends an assert message in the cycle after the write.
- R6: Assert and deassert messages never pulse in the same cycle. Neither is sent while the masked level is unchanged.
- R7: A primary non-fatal error (`pri_err_nf`) raises an error message when bit 8 or `dc_nf_en` is 1. A primary fatal error (`pri_err_f`) raises one when bit 8 or `dc_f_en` is 1. With all enables at 0, nothing is sent.
- R8: Secondary-side errors (`sec_err_nf`, `sec_err_f`) raise an error message only through `dc_nf_en` and `dc_f_en` respectively. Bit 8 has no effect on them.
- R9: `serr_msg` is a single-cycle pulse, sent the cycle after the qualified error condition rises. It does not repeat while the condition persists.
- R10: `mdpe_set` equals `par_err_det` while bit 6 is 1, and is 0 while bit 6 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_be | input | 2 | Byte enables for the 16-bit access |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data (combinational) |
| pme_req | input | 1 | Pending power-management interrupt request |
| hp_req | input | 1 | Pending hot-plug interrupt request |
| pri_err_nf | input | 1 | Non-fatal error detected on primary side |
| pri_err_f | input | 1 | Fatal error detected on primary side |
| sec_err_nf | input | 1 | Non-fatal error received on secondary side |
| sec_err_f | input | 1 | Fatal error received on secondary side |
| dc_nf_en | input | 1 | Device-control non-fatal reporting enable |
| dc_f_en | input | 1 | Device-control fatal reporting enable |
| par_err_det | input | 1 | Master data parity error detected |
| inta_asrt_msg | output | 1 | One-cycle INTA assert message request |
| inta_dsrt_msg | output | 1 | One-cycle INTA deassert message request |
| inta_level | output | 1 | Current masked INTA level |
| serr_msg | output | 1 | One-cycle error message request |
| mdpe_set | output | 1 | Gated set strobe for the parity error status bit |

## Verification
The bench first sets the disable bit while the interrupt is asserted and expects a deassert message. A design that only blocked new interrupts would leave the interrupt stuck high. It then clears the disable bit while a request is still pending and expects a fresh assert message; a level-only design would silently miss this.

Error conditions are held for several cycles, so a design that repeats `serr_msg` every cycle produces unexpected messages. Secondary-side errors are raised with only bit 8 set, to catch a design that OR-s bit 8 into every error path. Writes with partial byte enables and to a wrong address check that bits outside the three writable positions stay at zero.

// File: rtl/bridge_cmd_reg.sv
module bridge_cmd_reg #(
  parameter int ADDR_W     = 12,
  parameter int CMD_OFFSET = 'h004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_be,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              pme_req,
  input  logic              hp_req,
  input  logic              pri_err_nf,
  input  logic              pri_err_f,
  input  logic              sec_err_nf,
  input  logic              sec_err_f,
  input  logic              dc_nf_en,
  input  logic              dc_f_en,
  input  logic              par_err_det,
  output logic              inta_asrt_msg,
  output logic              inta_dsrt_msg,
  output logic              inta_level,
  output logic              serr_msg,
  output logic              mdpe_set
);

  localparam logic [ADDR_W-1:0] OFF = CMD_OFFSET[ADDR_W-1:0];

  logic int_dis, serr_en, perr_en;
  logic hit, lvl, lvl_q, qual, qual_q;
  logic unused_bits;

  assign hit = cfg_addr[ADDR_W-1:1] == OFF[ADDR_W-1:1];
  assign unused_bits = ^{cfg_addr[0], cfg_wdata[15:11], cfg_wdata[9], cfg_wdata[7], cfg_wdata[5:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_dis <= 1'b0;
      serr_en <= 1'b0;
      perr_en <= 1'b0;
    end else if (cfg_wr && hit) begin
      if (cfg_be[1]) begin
        int_dis <= cfg_wdata[10];
        serr_en <= cfg_wdata[8];
      end
      if (cfg_be[0]) perr_en <= cfg_wdata[6];
    end
  end

  assign cfg_rdata = hit ? {5'b0, int_dis, 1'b0, serr_en, 1'b0, perr_en, 6'b0} : 16'h0000;

  assign lvl = (pme_req | hp_req) & ~int_dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q         <= 1'b0;
      inta_asrt_msg <= 1'b0;
      inta_dsrt_msg <= 1'b0;
    end else begin
      lvl_q         <= lvl;
      inta_asrt_msg <= lvl & ~lvl_q;
      inta_dsrt_msg <= ~lvl & lvl_q;
    end
  end

  assign inta_level = lvl_q;

  assign qual = (pri_err_nf & (serr_en | dc_nf_en)) |
                (pri_err_f  & (serr_en | dc_f_en))  |
                (sec_err_nf & dc_nf_en) |
                (sec_err_f  & dc_f_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_q   <= 1'b0;
      serr_msg <= 1'b0;
    end else begin
      qual_q   <= qual;
      serr_msg <= qual & ~qual_q;
    end
  end

  assign mdpe_set = par_err_det & perr_en;

  // R6
  no_dual_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inta_asrt_msg && inta_dsrt_msg));

  // R3
  asrt_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_asrt_msg |-> $past(!int_dis && (pme_req || hp_req)));

  // R4
  retract_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_dis) && inta_level) |=> inta_dsrt_msg);

  // R5
  reassert_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(int_dis) && (pme_req || hp_req) && !inta_level) |=> inta_asrt_msg);

  // R9
  serr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_msg |=> !serr_msg);

  // R10
  mdpe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdpe_set |-> (par_err_det && cfg_rdata[6] == hit));

endmodule

// File: tb/bridge_cmd_reg_tb.sv
module bridge_cmd_reg_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [11:0] cfg_addr = 12'h004;
  logic [1:0]  cfg_be = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic pme_req = 0, hp_req = 0, pri_err_nf = 0, pri_err_f = 0;
  logic sec_err_nf = 0, sec_err_f = 0, dc_nf_en = 0, dc_f_en = 0, par_err_det = 0;
  logic inta_asrt_msg, inta_dsrt_msg, inta_level, serr_msg, mdpe_set;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef enum logic [1:0] {EV_ASRT, EV_DSRT, EV_SERR} ev_t;
  ev_t   exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  bridge_cmd_reg u_dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input ev_t e, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic seen(input ev_t e);
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL unexpected message actual=%s expected=none", e.name());
    end else begin
      ev_t x = exp_q.pop_front();
      string t = tag_q.pop_front();
      if (x != e) begin
        failures++;
        $display("FAIL %s actual=%s expected=%s", t, e.name(), x.name());
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (inta_asrt_msg) seen(EV_ASRT);
    if (inta_dsrt_msg) seen(EV_DSRT);
    if (serr_msg)      seen(EV_SERR);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] be, input logic [15:0] d);
    cyc(1);
    cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    cyc(1);
    cfg_wr = 0; cfg_addr = 12'h004;
  endtask

  task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string req);
    cfg_addr = a; #1;
    check(req, cfg_rdata, exp);
    cfg_addr = 12'h004;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    rd(12'h004, 16'h0000, "R1 reset value");
    check("R3 reset level", {15'b0, inta_level}, 16'h0);

    wr(12'h004, 2'b11, 16'hFFFF);
    rd(12'h004, 16'h0540, "R2 only 10/8/6 writable");
    rd(12'h005, 16'h0540, "R1 addr bit0 ignored");
    wr(12'h004, 2'b01, 16'h0000);
    rd(12'h004, 16'h0500, "R2 low byte enable");
    wr(12'h008, 2'b11, 16'h0000);
    rd(12'h004, 16'h0500, "R1 wrong address write ignored");
    rd(12'h008, 16'h0000, "R1 other offset reads zero");

    pme_req = 1;
    cyc(3);
    check("R3 masked while disabled", {15'b0, inta_level}, 16'h0);

    expect_ev(EV_ASRT, "R5 assert on enable");
    wr(12'h004, 2'b10, 16'h0000);
    cyc(1);
    check("R5 level after enable", {15'b0, inta_level}, 16'h1);
    hp_req = 1; cyc(2);
    pme_req = 0; cyc(2);
    check("R6 no msg while level held", {15'b0, inta_level}, 16'h1);
    expect_ev(EV_DSRT, "R4 deassert on drop");
    hp_req = 0; cyc(2);
    check("R4 level low", {15'b0, inta_level}, 16'h0);

    expect_ev(EV_ASRT, "R3 assert on request");
    hp_req = 1; cyc(2);
    expect_ev(EV_DSRT, "R4 retract on disable");
    wr(12'h004, 2'b10, 16'h0400);
    cyc(2);
    check("R4 level after disable", {15'b0, inta_level}, 16'h0);
    expect_ev(EV_ASRT, "R5 reassert");
    wr(12'h004, 2'b10, 16'h0000);
    cyc(2);
    expect_ev(EV_DSRT, "R4 drop again");
    hp_req = 0; cyc(2);

    pri_err_nf = 1; cyc(3);
    pri_err_nf = 0; cyc(1);
    wr(12'h004, 2'b10, 16'h0100);
    expect_ev(EV_SERR, "R7 primary nf via bit8");
    pri_err_nf = 1; cyc(5);
    pri_err_nf = 0; cyc(2);
    expect_ev(EV_SERR, "R9 fresh rise");
    pri_err_f = 1; cyc(4);
    pri_err_f = 0; cyc(2);
    sec_err_f = 1; sec_err_nf = 1; cyc(4);
    expect_ev(EV_SERR, "R8 secondary via devctl");
    dc_f_en = 1; cyc(3);
    sec_err_f = 0; sec_err_nf = 0; dc_f_en = 0; cyc(2);
    wr(12'h004, 2'b10, 16'h0000);
    dc_nf_en = 1;
    expect_ev(EV_SERR, "R7 primary nf via devctl");
    pri_err_nf = 1; cyc(3);
    pri_err_nf = 0; cyc(2);
    pri_err_f = 1; cyc(3);
    pri_err_f = 0; dc_nf_en = 0; cyc(2);

    par_err_det = 1; #1;
    check("R10 gate closed", {15'b0, mdpe_set}, 16'h0);
    wr(12'h004, 2'b01, 16'h0040);
    #1;
    check("R10 gate open", {15'b0, mdpe_set}, 16'h1);
    par_err_det = 0; #1;
    check("R10 follows detect", {15'b0, mdpe_set}, 16'h0);
    cyc(3);

    check("R6 all expected messages seen", 16'(exp_q.size()), 16'h0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule